// File: doc/BRIEF.md
# Serial Presence-Detect Byte Store with Two-Wire Target Port

This block holds 256 bytes of configuration data and serves them to a two-wire (I2C) bus controller. It runs on a fast system clock. SCL and SDA are oversampled through a two-flop synchronizer and a glitch filter. The block pulls SDA low to drive it, and the line is released otherwise.

The 7-bit target address is `1010` followed by three strap pins, with the top strap bit placed first. A write transfer carries one word-address byte that loads the internal pointer, followed by data bytes. A read transfer returns bytes starting at the current pointer. The pointer advances after each byte and wraps from 255 to 0.

Byte 63 always reports the 8-bit sum of bytes 0 to 62. The block updates it after every accepted write in that range. A write-protect pin refuses data bytes. The initial contents come from a parameter vector.

Top module: `spd_eeprom_i2c`

## Requirements
- R1: After reset, SDA is released (`sda_pull_o` = 0), the pointer is 0, and byte i holds byte i of the `INIT` parameter. The default image is byte i = (7*i + 3) mod 256.
- R2: The block acknowledges an address byte whose upper seven bits equal {1010, strap_i[2], strap_i[1], strap_i[0]}, with bit 0 = 0 for write and 1 for read. Any other address gets no acknowledge, and SDA stays released until the next START.
- R3: In a write transfer, the first byte after the address is acknowledged and loads the pointer. Each following data byte is acknowledged and stored at the pointer.
- R4: The pointer advances by one after each stored data byte and after each byte read, so sequential reads continue from where the last access left off.
- R5: The pointer wraps from 255 to 0, for both writes and reads.
- R6: Reading byte 63 returns the low 8 bits of the sum of bytes 0 to 62. The value reflects every accepted write to those bytes.
- R7: A data byte written to address 63 is acknowledged and advances the pointer, but it does not change the value read back from byte 63.
- R8: While `wp_i` = 1, the word-address byte is still acknowledged and still loads the pointer. Data bytes are not acknowledged, are not stored, and do not advance the pointer.
- R9: Read bytes are sent MSB first. A controller ACK (SDA low) on the ninth clock makes the block send the next byte. A NACK makes it release SDA and go idle.
- R10: A filtered SDA fall while SCL is high is a START, and a filtered SDA rise while SCL is high is a STOP. A repeated START restarts the address phase. An SDA pulse shorter than `FILT_LEN` system clocks is ignored.
- R11: The block changes its SDA drive only while SCL is low, except when releasing SDA at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Two-wire bus clock line, sampled |
| sda_i | input | 1 | Two-wire bus data line as seen on the wire |
| strap_i | input | 3 | Address strap pins, bit 2 is sent first |
| wp_i | input | 1 | Write protect, 1 refuses data bytes |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except at START and STOP edges. They also assume that every SCL level lasts many more system clocks than the filter length. The filter assertion further assumes `FILT_LEN` is at least 2. The bench keeps each quarter bit at 25 system clocks and drives the wire only at falling system-clock edges. Its single deliberate violation is a one-clock SDA pulse during idle, which exercises the glitch filter.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int SPD_AW = 8;
  localparam int SPD_DW = 8;
  localparam int SPD_DEPTH = 1 << SPD_AW;

  typedef enum logic [2:0] {
    T_IDLE, T_ADDR, T_ACK_A, T_WADDR, T_WDATA, T_ACK_W, T_RDATA, T_RACK
  } tgt_state_t;

  typedef enum logic [1:0] {M_IDLE, M_READ, M_MOD} upd_state_t;

  function automatic logic [SPD_DEPTH*SPD_DW-1:0] default_image();
    logic [SPD_DEPTH*SPD_DW-1:0] img;
    for (int i = 0; i < SPD_DEPTH; i++) img[i*SPD_DW +: SPD_DW] = SPD_DW'(i * 7 + 3);
    return img;
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3,
  parameter logic INIT_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= INIT_VAL;
      s2 <= INIT_VAL;
      clean_o <= INIT_VAL;
      cnt <= '0;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      if (s2 == clean_o) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        clean_o <= s2;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: a level change needs at least two consecutive agreeing samples
  p_filter_min_width_r10: assert property (@(posedge clk) disable iff (rst)
    (clean_o != $past(clean_o)) |-> ($past(s2, 1) == clean_o && $past(s2, 2) == clean_o));
endmodule

// File: rtl/spd_store.sv
module spd_store
  import spd_pkg::*;
#(
  parameter int AW = SPD_AW,
  parameter int DW = SPD_DW,
  parameter int CS_ADDR = 63,
  parameter logic [(1<<AW)*DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          wr_req,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] CSA = AW'(CS_ADDR);

  function automatic logic [DW-1:0] init_sum();
    logic [DW-1:0] s = '0;
    for (int i = 0; i < CS_ADDR; i++) s = s + INIT[i*DW +: DW];
    return s;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q, csum_q, wd_q;
  logic [AW-1:0] wa_q, ra_q, addr_mux;
  upd_state_t st_q;
  logic we;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*DW +: DW];

  assign addr_mux = (st_q != M_IDLE) ? wa_q : raddr;
  assign we = (st_q == M_MOD);

  always_ff @(posedge clk) begin
    if (we) mem[wa_q] <= wd_q;
    mem_q <= mem[addr_mux];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= M_IDLE;
      csum_q <= init_sum();
      wa_q <= '0;
      wd_q <= '0;
      ra_q <= '0;
    end else begin
      ra_q <= addr_mux;
      case (st_q)
        M_IDLE: if (wr_req && waddr != CSA) begin
          wa_q <= waddr;
          wd_q <= wdata;
          st_q <= M_READ;
        end
        M_READ: st_q <= M_MOD;
        default: begin
          if (wa_q < CSA) csum_q <= csum_q - mem_q + wd_q;
          st_q <= M_IDLE;
        end
      endcase
    end
  end

  assign rdata = (ra_q == CSA) ? csum_q : mem_q;

  // R7: the checksum location is never written through the array port
  p_no_cs_write_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> (wa_q != CSA));
  // R6: the checksum only moves right after a read-modify cycle
  p_csum_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q != M_MOD) |=> $stable(csum_q));
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import spd_pkg::*;
#(
  parameter int AW = SPD_AW,
  parameter int DW = SPD_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [2:0]    strap_i,
  input  logic          wp_i,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] ptr_o,
  output logic          wr_req_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          sda_low_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  tgt_state_t st_q;
  logic scl_d, sda_d, done_q, rw_q, cont_q;
  logic [2:0] bitcnt;
  logic [DW-1:0] sh;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_evt = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_evt  = scl_f & scl_d & ~sda_d & sda_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1; sda_d <= 1'b1;
      st_q <= T_IDLE; bitcnt <= '0; done_q <= 1'b0; sh <= '0;
      ptr_o <= '0; sda_low_o <= 1'b0; rw_q <= 1'b0; cont_q <= 1'b0;
      wr_req_o <= 1'b0; waddr_o <= '0; wdata_o <= '0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      wr_req_o <= 1'b0;
      if (start_evt) begin
        st_q <= T_ADDR; bitcnt <= '0; done_q <= 1'b0; sda_low_o <= 1'b0;
      end else if (stop_evt) begin
        st_q <= T_IDLE; sda_low_o <= 1'b0;
      end else begin
        case (st_q)
          T_ADDR, T_WADDR, T_WDATA: begin
            if (scl_rise) begin
              sh <= {sh[DW-2:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
              done_q <= (bitcnt == 3'd7);
            end else if (scl_fall && done_q) begin
              done_q <= 1'b0;
              if (st_q == T_ADDR) begin
                if (sh[7:1] == {4'b1010, strap_i}) begin
                  rw_q <= sh[0]; sda_low_o <= 1'b1; st_q <= T_ACK_A;
                end else begin
                  st_q <= T_IDLE;
                end
              end else if (st_q == T_WADDR) begin
                ptr_o <= sh; sda_low_o <= 1'b1; st_q <= T_ACK_W;
              end else begin
                if (!wp_i) begin
                  wr_req_o <= 1'b1; waddr_o <= ptr_o; wdata_o <= sh;
                  ptr_o <= ptr_o + ONE; sda_low_o <= 1'b1;
                end
                st_q <= T_ACK_W;
              end
            end
          end
          T_ACK_A: if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin
              st_q <= T_RDATA; sh <= rdata; sda_low_o <= ~rdata[DW-1];
              ptr_o <= ptr_o + ONE; done_q <= 1'b0;
            end else begin
              st_q <= T_WADDR; sda_low_o <= 1'b0;
            end
          end
          T_ACK_W: if (scl_fall) begin
            sda_low_o <= 1'b0; st_q <= T_WDATA; bitcnt <= '0;
          end
          T_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
              done_q <= (bitcnt == 3'd7);
            end else if (scl_fall) begin
              if (done_q) begin
                done_q <= 1'b0; sda_low_o <= 1'b0; st_q <= T_RACK;
              end else begin
                sh <= {sh[DW-2:0], 1'b0}; sda_low_o <= ~sh[DW-2];
              end
            end
          end
          T_RACK: begin
            if (scl_rise) cont_q <= ~sda_f;
            else if (scl_fall) begin
              if (cont_q) begin
                st_q <= T_RDATA; sh <= rdata; sda_low_o <= ~rdata[DW-1];
                ptr_o <= ptr_o + ONE; bitcnt <= '0;
              end else begin
                st_q <= T_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: drive changes only with SCL low, or as the release at START/STOP
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    (sda_low_o != $past(sda_low_o)) |-> (!scl_f || $past(start_evt || stop_evt)));
  // R10: a STOP always leaves SDA released
  p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_low_o);
endmodule

// File: rtl/spd_eeprom_i2c.sv
module spd_eeprom_i2c
  import spd_pkg::*;
#(
  parameter int AW = SPD_AW,
  parameter int DW = SPD_DW,
  parameter int FILT_LEN = 3,
  parameter int CS_ADDR = 63,
  parameter logic [(1<<AW)*DW-1:0] INIT = default_image()
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  logic scl_f, sda_f, wr_req;
  logic [AW-1:0] ptr, waddr;
  logic [DW-1:0] rdata, wdata;

  i2c_line_filter #(.FILT_LEN(FILT_LEN), .INIT_VAL(1'b1)) u_scl_filt (
    .clk(clk), .rst(rst), .raw_i(scl_i), .clean_o(scl_f));
  i2c_line_filter #(.FILT_LEN(FILT_LEN), .INIT_VAL(1'b1)) u_sda_filt (
    .clk(clk), .rst(rst), .raw_i(sda_i), .clean_o(sda_f));

  i2c_target_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .strap_i(strap_i),
    .wp_i(wp_i), .rdata(rdata), .ptr_o(ptr), .wr_req_o(wr_req),
    .waddr_o(waddr), .wdata_o(wdata), .sda_low_o(sda_pull_o));

  spd_store #(.AW(AW), .DW(DW), .CS_ADDR(CS_ADDR), .INIT(INIT)) u_store (
    .clk(clk), .rst(rst), .raddr(ptr), .rdata(rdata), .wr_req(wr_req),
    .waddr(waddr), .wdata(wdata));
endmodule

// File: tb/test_spd_eeprom_i2c.sv
module test_spd_eeprom_i2c;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 25;
  localparam logic [7:0] AW_ADDR = 8'hAA;
  localparam logic [7:0] AR_ADDR = 8'hAB;

  logic clk = 0, rst = 1, scl_m = 1, sda_m = 1, wp = 0;
  logic [2:0] strap = 3'b101;
  logic pull, sda_line;
  int n_chk = 0, n_fail = 0;
  logic [7:0] img [256];
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic rd_phase = 0;

  assign sda_line = sda_m & ~pull;
  always #(CLK_PERIOD/2) clk = ~clk;

  spd_eeprom_i2c i_spd_eeprom_i2c (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_pull_o(pull));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] model_sum();
    logic [7:0] s = 0;
    for (int i = 0; i < 63; i++) s = s + img[i];
    return s;
  endfunction

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask
  task automatic i2c_start();
    sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait();
  endtask
  task automatic i2c_stop();
    sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait(); qwait();
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1; qwait(); scl_m = 1; qwait(); b = sda_line; qwait(); scl_m = 0; qwait();
  endtask
  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    check(!a == exp_ack, tag, !a, exp_ack);
  endtask
  // driver: push expected byte, then clock it out; the monitor compares
  task automatic recv_byte(input logic [7:0] expv, input logic mack, input string tag);
    logic b;
    exp_q.push_back(expv); tag_q.push_back(tag);
    rd_phase = 1;
    for (int i = 0; i < 8; i++) get_bit(b);
    rd_phase = 0;
    put_bit(!mack);
  endtask
  task automatic set_ptr(input logic [7:0] a);
    i2c_start(); send_byte(AW_ADDR, 1, "R2"); send_byte(a, 1, "R3");
  endtask
  task automatic write_bytes(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1);
    set_ptr(a);
    send_byte(d0, 1, "R3"); send_byte(d1, 1, "R3");
    i2c_stop();
    if (a != 63) img[a] = d0;
    if (8'(a + 1) != 63) img[8'(a + 1)] = d1;
    img[63] = model_sum();
  endtask

  // monitor: assemble the bits read on SCL rise and compare with the queue
  initial begin
    logic [7:0] got;
    int nb;
    nb = 0; got = 0;
    forever begin
      @(posedge scl_m);
      if (rd_phase) begin
        got = {got[6:0], sda_line};
        nb++;
        if (nb == 8) begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(got == e, t, got, e);
          nb = 0;
        end
      end
    end
  end

  // R11: drive seen at the wire holds steady through each SCL high phase
  initial begin
    logic p;
    forever begin
      @(posedge scl_m); p = pull;
      @(negedge scl_m);
      if (pull !== p) check(0, "R11", pull, p);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) img[i] = 8'(i * 7 + 3);
    img[63] = model_sum();
    repeat (5) @(negedge clk); rst = 0;
    repeat (20) @(negedge clk);
    check(pull == 0, "R1 reset release", pull, 0);

    // R1/R4: read from reset pointer, R9 NACK releases
    i2c_start(); send_byte(AR_ADDR, 1, "R2 read addr");
    recv_byte(img[0], 1, "R1 byte0"); recv_byte(img[1], 0, "R4 byte1");
    repeat (10) @(negedge clk);
    check(pull == 0, "R9 release after NACK", pull, 0);
    i2c_stop();

    // R2: wrong strap value
    i2c_start(); send_byte(8'hA6, 0, "R2 mismatch"); i2c_stop();

    // R3 write, R10 repeated start random read, R4 increment
    write_bytes(8'h05, 8'h11, 8'h22);
    set_ptr(8'h05); sda_m = 1; qwait(); i2c_start();
    send_byte(AR_ADDR, 1, "R10 repeated start");
    recv_byte(img[5], 1, "R3 byte5"); recv_byte(img[6], 1, "R4 byte6");
    recv_byte(img[7], 0, "R4 byte7"); i2c_stop();

    // R6 checksum
    set_ptr(8'd62); sda_m = 1; qwait(); i2c_start(); send_byte(AR_ADDR, 1, "R2");
    recv_byte(img[62], 1, "R4 byte62"); recv_byte(img[63], 0, "R6 checksum"); i2c_stop();

    // R7 write to 63 ignored
    write_bytes(8'd63, 8'h99, 8'h44);
    set_ptr(8'd63); sda_m = 1; qwait(); i2c_start(); send_byte(AR_ADDR, 1, "R2");
    recv_byte(img[63], 1, "R7 checksum kept"); recv_byte(8'h44, 0, "R7 next byte"); i2c_stop();

    // R5 wrap on write and read, R6 update from byte 0
    write_bytes(8'hFF, 8'hA1, 8'hB2);
    set_ptr(8'hFE); sda_m = 1; qwait(); i2c_start(); send_byte(AR_ADDR, 1, "R2");
    recv_byte(img[254], 1, "R5 byte254"); recv_byte(8'hA1, 1, "R5 byte255");
    recv_byte(8'hB2, 0, "R5 byte0 wrapped"); i2c_stop();
    set_ptr(8'd63); sda_m = 1; qwait(); i2c_start(); send_byte(AR_ADDR, 1, "R2");
    recv_byte(img[63], 0, "R6 checksum after byte0"); i2c_stop();

    // R8 write protect
    wp = 1;
    set_ptr(8'h10); send_byte(8'h77, 0, "R8 data refused"); i2c_stop();
    wp = 0;
    set_ptr(8'h10); sda_m = 1; qwait(); i2c_start(); send_byte(AR_ADDR, 1, "R2");
    recv_byte(img[16], 0, "R8 content kept"); i2c_stop();

    // R10 short SDA pulse during idle is no START
    @(negedge clk); sda_m = 0; @(negedge clk); sda_m = 1;
    qwait(); scl_m = 0; qwait();
    send_byte(AR_ADDR, 0, "R10 glitch ignored");
    i2c_stop();

    check(exp_q.size() == 0, "R9 all reads seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule